// File: doc/BRIEF.md
# Interrupt Request Capture and Masking

This block sits in front of a priority resolver. It watches a set of interrupt lines and turns each detected event into a held pending bit. Each line can be set to edge or level detection. An edge line can react to a rising or a falling edge. Software can also raise pending bits, or clear one of them by giving its bit number. An acknowledge input from the downstream logic clears the request that was taken.

A per-line mask and a global enable gate only the path from the pending bits to the request vector. An event on a masked line is still latched and waits. Inputs first pass through a synchroniser of parameter depth. A registered copy of the synchronised value feeds the edge compare.

Configuration and commands use a single write strobe with an address and a data word. Every command takes effect at the clock edge on which the strobe is sampled.

Top module: `irq_capture`

## Requirements
- R1: While reset is held and directly after it, `pending_o` and `req_o` are all zero.
- R2: After reset every line is edge-triggered on the rising edge. With the default two synchroniser stages, a low-to-high input change sets its pending bit at the third rising clock edge after the change, and the bit stays set after the input falls.
- R3: Writing 1 to a line's bit at address 1 selects the falling edge. Such a line ignores a rising edge, and its pending bit is set at the third clock edge after a high-to-low change.
- R4: Writing 1 to a line's bit at address 0 selects level mode, where high is active. A high input sets the pending bit. A high-to-low change of the synchronised input clears the bit at the third edge after the change, so the event is lost.
- R5: The mask is applied after the pending register. A masked event is still latched in `pending_o`. `req_o` equals `pending_o` AND NOT mask, AND the global enable.
- R6: After reset all mask bits at address 2 are 1, which blocks every line, and the global enable is 0.
- R7: Bit 0 of address 3 is the global enable. While it is 0, `req_o` is all zero whatever the masks hold.
- R8: A write to address 4 sets every pending bit whose data bit is 1. Several bits can be set in one write, and bits written 0 are left unchanged.
- R9: A write to address 5 clears the single pending bit whose number is in the low data bits.
- R10: `ack_valid` with `ack_id` clears that pending bit at the next edge.
- R11: A set of a bit (hardware event or address 4 write) in the same cycle as a clear of that bit (address 5, acknowledge or level drop) leaves the bit set.
- R12: Writes to addresses 6 and 7 change neither `pending_o` nor `req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IN | Raw interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | N_IN | Write data |
| ack_valid | input | 1 | Acknowledge from the resolver |
| ack_id | input | $clog2(N_IN) | Number of the acknowledged line |
| pending_o | output | N_IN | Latched pending requests |
| req_o | output | N_IN | Masked, enabled pending requests |

## Verification
Directed sequences cover each detection kind on its own. A rising edge on a default line and a rising edge on a falling-polarity line tell the two polarities apart. A level line that is acknowledged while still high, then dropped, separates level behaviour from edge latching. Software sets under different mask and global-enable settings show that the gating acts only after the latch. A same-cycle set and acknowledge of one bit shows which side wins. Random traffic then mixes toggling inputs, configuration changes, writes to every address and acknowledges, and is compared each cycle with a reference model built from the stated latencies.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_TRIG   = 3'd0,
      A_POL    = 3'd1,
      A_MASK   = 3'd2,
      A_GEN    = 3'd3,
      A_SWSET  = 3'd4,
      A_CLRNUM = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/irq_line_detect.sv
module irq_line_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   input  logic lvl_mode,
   input  logic fall_sel,
   output logic set_ev,
   output logic drop_ev
);
   logic cur;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cur = raw_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (SYNC_STAGES == 1) chain <= raw_in;
            else chain <= {chain[SYNC_STAGES-2:0], raw_in};
         end
         assign cur = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= cur;
   end

   always_comb begin
      if (lvl_mode)      set_ev = cur;
      else if (fall_sel) set_ev = prev & ~cur;
      else               set_ev = cur & ~prev;
      drop_ev = lvl_mode & prev & ~cur;
   end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_cap_pkg::*;
#(
   parameter int N_IN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [N_IN-1:0]   wr_data,
   output logic [N_IN-1:0]   trig_lvl,
   output logic [N_IN-1:0]   pol_fall,
   output logic [N_IN-1:0]   mask,
   output logic              gen,
   output logic [N_IN-1:0]   sw_set,
   output logic [N_IN-1:0]   sw_clr
);
   localparam int ID_W = (N_IN > 1) ? $clog2(N_IN) : 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_lvl <= '0;
         pol_fall <= '0;
         mask     <= '1;
         gen      <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            A_TRIG:  trig_lvl <= wr_data;
            A_POL:   pol_fall <= wr_data;
            A_MASK:  mask     <= wr_data;
            A_GEN:   gen      <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      sw_set = '0;
      sw_clr = '0;
      if (wr_en && wr_addr == A_SWSET) sw_set = wr_data;
      for (int i = 0; i < N_IN; i++) begin
         if (wr_en && wr_addr == A_CLRNUM && int'(wr_data[ID_W-1:0]) == i)
            sw_clr[i] = 1'b1;
      end
   end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int N_IN = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] set_vec,
   input  logic [N_IN-1:0] clr_vec,
   output logic [N_IN-1:0] pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= '0;
      else        pending <= set_vec | (pending & ~clr_vec);
   end
endmodule

// File: rtl/irq_capture.sv
module irq_capture
   import irq_cap_pkg::*;
#(
   parameter int N_IN        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN-1:0]         irq_in,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [N_IN-1:0]         wr_data,
   input  logic                    ack_valid,
   input  logic [$clog2(N_IN)-1:0] ack_id,
   output logic [N_IN-1:0]         pending_o,
   output logic [N_IN-1:0]         req_o
);
   localparam int ID_W = $clog2(N_IN);

   generate
      if (N_IN < 2) begin : g_bad_n
         $error("irq_capture: N_IN must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("irq_capture: SYNC_STAGES must be in 0..4");
      end
   endgenerate

   logic [N_IN-1:0] trig_lvl, pol_fall, mask;
   logic            gen;
   logic [N_IN-1:0] sw_set, sw_clr;
   logic [N_IN-1:0] hw_set, hw_drop;
   logic [N_IN-1:0] ack_clr;
   logic [N_IN-1:0] set_all, clr_all;

   irq_cfg_regs #(.N_IN(N_IN)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .trig_lvl (trig_lvl),
      .pol_fall (pol_fall),
      .mask     (mask),
      .gen      (gen),
      .sw_set   (sw_set),
      .sw_clr   (sw_clr)
   );

   generate
      for (genvar g = 0; g < N_IN; g++) begin : g_line
         irq_line_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (irq_in[g]),
            .lvl_mode (trig_lvl[g]),
            .fall_sel (pol_fall[g]),
            .set_ev   (hw_set[g]),
            .drop_ev  (hw_drop[g])
         );
         assign ack_clr[g] = ack_valid && (int'(ack_id) == g);
      end
   endgenerate

   assign set_all = hw_set | sw_set;
   assign clr_all = sw_clr | ack_clr | hw_drop;

   irq_pend_reg #(.N_IN(N_IN)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_all),
      .clr_vec (clr_all),
      .pending (pending_o)
   );

   assign req_o = gen ? (pending_o & ~mask) : '0;
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk
   import irq_cap_pkg::*;
#(
   parameter int N_IN = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [ADDR_W-1:0]       wr_addr,
   input logic [N_IN-1:0]         wr_data,
   input logic                    ack_valid,
   input logic [$clog2(N_IN)-1:0] ack_id,
   input logic [N_IN-1:0]         hw_set,
   input logic [N_IN-1:0]         pending_o,
   input logic [N_IN-1:0]         req_o,
   input logic                    gen
);
   localparam int ID_W = $clog2(N_IN);

   // R5: a forwarded request is always backed by a latched pending bit
   a_r5_req_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o & ~pending_o) == '0);

   // R7: global enable off blocks every request
   a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !gen |-> req_o == '0);

   // R8: software set bits are pending one edge later
   a_r8_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_SWSET) |=> (pending_o & $past(wr_data)) == $past(wr_data));

   // R9: clear by number without a competing hardware set
   a_r9_clear_num: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CLRNUM && !hw_set[wr_data[ID_W-1:0]])
      |=> !pending_o[$past(wr_data[ID_W-1:0])]);

   // R10: acknowledge clears the accepted line
   a_r10_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !hw_set[ack_id] && !(wr_en && wr_addr == A_SWSET && wr_data[ack_id]))
      |=> !pending_o[$past(ack_id)]);

   // R11: hardware events always land, whatever is cleared in the same cycle
   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      |hw_set |=> (pending_o & $past(hw_set)) == $past(hw_set));
endmodule

bind irq_capture irq_capture_chk #(.N_IN(N_IN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .ack_valid (ack_valid),
   .ack_id    (ack_id),
   .hw_set    (hw_set),
   .pending_o (pending_o),
   .req_o     (req_o),
   .gen       (gen)
);

// File: tb/irq_capture_tb.sv
module irq_capture_tb;
   localparam int N = 16;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [N-1:0]  wr_data = '0;
   logic          ack_valid = 1'b0;
   logic [3:0]    ack_id = '0;
   logic [N-1:0]  pending_o, req_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_capture u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ack_valid(ack_valid),
      .ack_id(ack_id), .pending_o(pending_o), .req_o(req_o)
   );

   // reference model built from the requirement latencies
   logic [N-1:0] m_h1, m_h2, m_h3, m_trig, m_pol, m_mask, m_pend;
   logic         m_gen;

   function automatic logic [N-1:0] exp_req(input logic [N-1:0] p, input logic [N-1:0] mk,
                                            input logic g);
      return g ? (p & ~mk) : '0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h1 = '0; m_h2 = '0; m_h3 = '0;
         m_trig = '0; m_pol = '0; m_mask = '1; m_gen = 1'b0; m_pend = '0;
      end else begin
         logic [N-1:0] s, c;
         s = '0; c = '0;
         for (int i = 0; i < N; i++) begin
            if (m_trig[i]) begin
               s[i] = m_h2[i];
               c[i] = m_h3[i] & ~m_h2[i];
            end else if (m_pol[i]) s[i] = m_h3[i] & ~m_h2[i];
            else                   s[i] = m_h2[i] & ~m_h3[i];
         end
         if (wr_en && wr_addr == 3'd4) s = s | wr_data;
         if (wr_en && wr_addr == 3'd5) c[wr_data[3:0]] = 1'b1;
         if (ack_valid) c[ack_id] = 1'b1;
         m_pend = s | (m_pend & ~c);
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_trig = wr_data;
               3'd1: m_pol  = wr_data;
               3'd2: m_mask = wr_data;
               3'd3: m_gen  = wr_data[0];
               default: ;
            endcase
         end
         m_h3 = m_h2; m_h2 = m_h1; m_h1 = irq_in;
      end
   end

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic ack(input int id);
      ack_valid = 1'b1; ack_id = 4'(id);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   initial begin
      cyc(WATCHDOG);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED1));
      cyc(2);
      chk("R1 pending in reset", pending_o, '0);
      chk("R1 req in reset", req_o, '0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 pending after reset", pending_o, '0);

      wr(3'd4, 16'hFFFF);
      chk("R8 multi-bit sw set", pending_o, 16'hFFFF);
      chk("R6 R7 req blocked after reset", req_o, '0);
      wr(3'd3, 16'h0001);
      chk("R6 masks all set after reset", req_o, '0);
      wr(3'd2, 16'h0000);
      chk("R5 req follows pending", req_o, 16'hFFFF);
      wr(3'd3, 16'h0000);
      chk("R7 global off", req_o, '0);
      wr(3'd3, 16'h0001);
      wr(3'd5, 16'h0005);
      chk("R9 clear bit 5", pending_o, 16'hFFDF);
      ack(0);
      chk("R10 ack bit 0", pending_o, 16'hFFDE);
      for (int i = 0; i < N; i++) wr(3'd5, 16'(i));
      chk("R9 all cleared", pending_o, '0);
      wr(3'd6, 16'hFFFF);
      wr(3'd7, 16'hFFFF);
      chk("R12 ignored addr pending", pending_o, '0);
      chk("R12 ignored addr req", req_o, '0);
      wr(3'd4, 16'h0001);
      chk("R12 config intact", req_o, 16'h0001);
      wr(3'd5, 16'h0000);

      // R2 rising edge default
      irq_in[3] = 1'b1;
      cyc(2);
      chk("R2 not yet after two edges", pending_o, '0);
      cyc(1);
      chk("R2 set at third edge", pending_o, 16'h0008);
      irq_in[3] = 1'b0;
      cyc(4);
      chk("R2 stays after input falls", pending_o, 16'h0008);
      wr(3'd5, 16'h0003);

      // R3 falling polarity
      wr(3'd1, 16'h0080);
      irq_in[7] = 1'b1;
      cyc(4);
      chk("R3 rising ignored", pending_o, '0);
      irq_in[7] = 1'b0;
      cyc(2);
      chk("R3 not yet", pending_o, '0);
      cyc(1);
      chk("R3 falling edge sets", pending_o, 16'h0080);
      wr(3'd5, 16'h0007);
      wr(3'd1, 16'h0000);

      // R4 level mode
      wr(3'd0, 16'h0200);
      irq_in[9] = 1'b1;
      cyc(3);
      chk("R4 level high sets", pending_o, 16'h0200);
      ack(9);
      chk("R4 R11 ack while level high", pending_o, 16'h0200);
      irq_in[9] = 1'b0;
      cyc(2);
      chk("R4 before drop seen", pending_o, 16'h0200);
      cyc(1);
      chk("R4 event lost on drop", pending_o, '0);
      wr(3'd0, 16'h0000);

      // R11 sw set and ack of same bit
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0004;
      ack_valid = 1'b1; ack_id = 4'd2;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; ack_valid = 1'b0;
      chk("R11 set beats ack", pending_o, 16'h0004);
      wr(3'd5, 16'h0002);

      // R5 masked event still latched
      wr(3'd2, 16'h0010);
      irq_in[4] = 1'b1;
      cyc(3);
      chk("R5 masked still pending", pending_o, 16'h0010);
      chk("R5 masked not forwarded", req_o, '0);
      irq_in[4] = 1'b0;
      cyc(3);
      wr(3'd5, 16'h0004);

      // random phase against the model
      for (int k = 0; k < 3000; k++) begin
         int r;
         chk("R2 R3 R4 R8 R9 R10 R11 pending model", pending_o, m_pend);
         chk("R5 R7 req model", req_o, exp_req(m_pend, m_mask, m_gen));
         for (int i = 0; i < N; i++)
            if ($urandom_range(0, 7) == 0) irq_in[i] = ~irq_in[i];
         r = $urandom_range(0, 9);
         wr_en = (r < 4);
         wr_addr = 3'($urandom_range(0, 7));
         wr_data = 16'($urandom);
         ack_valid = ($urandom_range(0, 3) == 0);
         ack_id = 4'($urandom_range(0, 15));
         @(negedge clk);
      end
      wr_en = 1'b0; ack_valid = 1'b0;
      chk("R5 final model", pending_o, m_pend);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule